// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a synchronous request port to an external asynchronous static RAM. The RAM has a 16-bit data bus and separate enables for its lower and upper byte. A request carries a direction, an address, write data and a two-bit byte mask. It is taken on a valid/ready handshake. The sequencer then plays out a fixed series of phases, each counted in clock cycles, on the memory's chip-enable, write-enable, output-enable and byte-lane strobes. It also controls the output enable of its own data-bus driver.

Writes are controlled by write-enable, and output-enable stays asserted throughout. The data driver is therefore switched on only after write-enable has been low long enough for the memory to float its outputs. The driver is switched off again shortly after write-enable rises. Between accesses, chip-enable stays low if another request is taken at once. A change of direction on an unchanged address forces a one-cycle chip-enable high gap. A read holds the strobes low for an access count, captures the bus, and presents the word with a one-cycle valid pulse.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and after it falls, chip-enable, write-enable, output-enable and both byte lanes are high, the data driver is disabled, and ready is high once reset is low.
- R2: After a write is accepted, the strobes hold chip-enable low, output-enable low and write-enable high for T_SETUP cycles. Write-enable is then low for T_TURN + T_PULSE cycles, while chip-enable and output-enable stay low.
- R3: The data driver turns on only after write-enable has been low for T_TURN cycles. It then drives the request's write data for T_PULSE cycles with write-enable low, plus T_HOLD cycles after write-enable rises, and is off for the rest of the access.
- R4: Mask bit 0 set drives the lower byte lane (data bits 7:0) low, and mask bit 1 set drives the upper byte lane (bits 15:8) low. This lasts from the first setup cycle through the last hold cycle. A clear mask bit leaves that byte of the memory unchanged, and a mask of 00 changes nothing.
- R5: The address output changes only in a cycle where write-enable is high both before and after the change. It holds the request's address for the whole access, including recovery.
- R6: After the data hold, both byte lanes go high and the driver is off for T_RECOV cycles, with chip-enable still low. Only then is ready raised.
- R7: A read holds chip-enable, output-enable and both byte lanes low, and write-enable high, for T_ACCESS cycles. It then captures the bus and pulses read-valid for exactly one cycle with that word. Both lanes go high for T_TURN cycles before ready is raised.
- R8: If a request is accepted while chip-enable is still low from the previous access, to the same address and with the opposite direction, chip-enable (with output-enable and both lanes) goes high for exactly one cycle before the new access begins. A direction change to a different address has no gap.
- R9: Ready is low from the cycle after acceptance until recovery ends. While ready is high, write-enable is high and the data driver is off.
- R10: An idle cycle with no request returns chip-enable, output-enable and both lanes to high on the following cycle.
- R11: Write-enable is never low while chip-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle pulse with captured read word |
| rd_data | output | DATA_W | Captured read word |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_lb_n | output | 1 | Lower byte lane, active low |
| mem_ub_n | output | 1 | Upper byte lane, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data bus as seen from the memory |

## Verification
Two events can coincide at the edge where recovery ends: acceptance of the next request and the return to idle. Acceptance decides in that same cycle whether the new access keeps chip-enable low or inserts the one-cycle gap. The bench provokes this by issuing each request the moment ready is seen high. It alternates direction on an equal address, and also on a different address. It judges the outcome cycle by cycle against a strobe profile shifted by one cycle when a gap is due, and against read data scoreboarded from its own shadow of the memory.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int T_SETUP  = 2,
  parameter int T_TURN   = 1,
  parameter int T_PULSE  = 3,
  parameter int T_HOLD   = 1,
  parameter int T_RECOV  = 2,
  parameter int T_ACCESS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CW = $clog2(T_SETUP + T_TURN + T_PULSE + T_HOLD + T_RECOV + T_ACCESS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_SETUP, S_TURN, S_PULSE, S_HOLD, S_RECOV, S_RACC
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic              lat_wr;
  logic [1:0]        lat_mask;
  logic [DATA_W-1:0] wdata_q;

  initial begin
    assert (T_SETUP >= 1 && T_TURN >= 1 && T_PULSE >= 1 && T_HOLD >= 1 &&
            T_RECOV >= 1 && T_ACCESS >= 1 && DATA_W >= 2);
  end

  assign req_ready  = (st == S_IDLE) && !rst;
  assign mem_dq_out = wdata_q;

  wire       accept   = req_ready && req_valid;
  wire       need_gap = !mem_ce_n && (req_write != lat_wr) && (req_addr == mem_addr);
  wire       launch   = (accept && !need_gap) || (st == S_GAP);
  wire       go_wr    = (st == S_GAP) ? lat_wr   : req_write;
  wire [1:0] go_mask  = (st == S_GAP) ? lat_mask : req_mask;
  wire       cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      lat_wr    <= 1'b0;
      lat_mask  <= 2'b00;
      wdata_q   <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        lat_wr   <= req_write;
        lat_mask <= req_mask;
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (launch) begin
        st       <= go_wr ? S_SETUP : S_RACC;
        mem_ce_n <= 1'b0;
        mem_oe_n <= 1'b0;
        mem_we_n <= 1'b1;
        mem_lb_n <= go_wr ? !go_mask[0] : 1'b0;
        mem_ub_n <= go_wr ? !go_mask[1] : 1'b0;
        cnt      <= go_wr ? CW'(T_SETUP - 1) : CW'(T_ACCESS - 1);
      end else begin
        case (st)
          S_IDLE: begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            if (accept) st <= S_GAP;
          end
          S_SETUP:
            if (cnt_zero) begin
              st       <= S_TURN;
              mem_we_n <= 1'b0;
              cnt      <= CW'(T_TURN - 1);
            end else cnt <= cnt - 1'b1;
          S_TURN:
            if (cnt_zero) begin
              st        <= S_PULSE;
              mem_dq_oe <= 1'b1;
              cnt       <= CW'(T_PULSE - 1);
            end else cnt <= cnt - 1'b1;
          S_PULSE:
            if (cnt_zero) begin
              st       <= S_HOLD;
              mem_we_n <= 1'b1;
              cnt      <= CW'(T_HOLD - 1);
            end else cnt <= cnt - 1'b1;
          S_HOLD:
            if (cnt_zero) begin
              st        <= S_RECOV;
              mem_dq_oe <= 1'b0;
              mem_lb_n  <= 1'b1;
              mem_ub_n  <= 1'b1;
              cnt       <= CW'(T_RECOV - 1);
            end else cnt <= cnt - 1'b1;
          S_RACC:
            if (cnt_zero) begin
              st       <= S_RECOV;
              rd_data  <= mem_dq_in;
              rd_valid <= 1'b1;
              mem_lb_n <= 1'b1;
              mem_ub_n <= 1'b1;
              cnt      <= CW'(T_TURN - 1);
            end else cnt <= cnt - 1'b1;
          S_RECOV:
            if (cnt_zero) st <= S_IDLE;
            else cnt <= cnt - 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_addr_we_high_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));

  p_ce_before_we_r11: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  p_drive_after_we_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));

  p_no_drive_at_we_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !mem_dq_oe);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_we_n && !mem_dq_oe));

  p_gap_ce_high_r8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !mem_ce_n && (req_write != lat_wr) && (req_addr == mem_addr))
      |=> (mem_ce_n && mem_oe_n));

endmodule

// File: tb/sram_seq_tb.sv
module sram_seq_tb_top;
  localparam int AW = 18, DW = 16;
  localparam int S = 2, TT = 1, P = 3, H = 1, R = 2, A = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mask = 2'b00;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [0:255];
  logic [DW-1:0] shadow [0:255];
  logic [DW-1:0] exp_q [$];

  always #4 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .T_SETUP(S), .T_TURN(TT), .T_PULSE(P),
             .T_HOLD(H), .T_RECOV(R), .T_ACCESS(A)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : '0;

  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read-valid", 32'(rd_data), 32'hx);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R7 read data", 32'(rd_data), 32'(e));
      end
    end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] m, input bit gap);
    int off, tot;
    off = gap ? 1 : 0;
    tot = wr ? S + TT + P + H + R : A + TT;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    if (wr) begin
      if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    end else exp_q.push_back(shadow[a[7:0]]);
    for (int k = 0; k <= tot + off; k++) begin
      logic [6:0] ev, av;
      string tag;
      int j;
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      j = k - off;
      av = {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready};
      if (j < 0)                  begin ev = 7'b1111100; tag = "R8 chip-enable gap"; end
      else if (j == tot)          begin ev = 7'b0101101; tag = "R9 ready after recovery"; end
      else if (!wr) begin
        if (j < A)                begin ev = 7'b0100000; tag = "R7 read access"; end
        else                      begin ev = 7'b0101100; tag = "R7 read turnaround"; end
        chk(rd_valid == (j == A), "R7 valid timing", 32'(rd_valid), 32'(j == A));
      end
      else if (j < S)             begin ev = {3'b010, ~m[0], ~m[1], 2'b00}; tag = "R2 R4 setup"; end
      else if (j < S + TT)        begin ev = {3'b000, ~m[0], ~m[1], 2'b00}; tag = "R2 R3 turn"; end
      else if (j < S + TT + P)    begin ev = {3'b000, ~m[0], ~m[1], 2'b10}; tag = "R3 R4 pulse";
        chk(mem_dq_out == d, "R3 write data", 32'(mem_dq_out), 32'(d)); end
      else if (j < S + TT + P + H) begin ev = {3'b010, ~m[0], ~m[1], 2'b10}; tag = "R3 hold";
        chk(mem_dq_out == d, "R3 hold data", 32'(mem_dq_out), 32'(d)); end
      else                        begin ev = 7'b0101100; tag = "R6 recovery"; end
      chk(av == ev, tag, 32'(av), 32'(ev));
      chk(mem_addr == a, "R5 address held", 32'(mem_addr), 32'(a));
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i]  = 16'(i * 16'h0101) ^ 16'h5A5A;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
    end
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe} == 6'b111110,
        "R1 strobes in reset", 32'({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}), 32'h3E);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk({mem_ce_n, mem_we_n, mem_dq_oe} == 3'b110, "R1 idle strobes", 32'({mem_ce_n, mem_we_n, mem_dq_oe}), 32'h6);

    access(1'b1, 18'h10, 16'h1234, 2'b11, 1'b0);
    access(1'b0, 18'h10, 16'h0,    2'b00, 1'b1);   // R8 write->read same address
    access(1'b1, 18'h10, 16'hABCD, 2'b01, 1'b1);   // R8 read->write, R4 lower only
    access(1'b1, 18'h20, 16'h5566, 2'b10, 1'b0);   // R4 upper only
    access(1'b0, 18'h20, 16'h0,    2'b00, 1'b1);
    access(1'b1, 18'h30, 16'hFFFF, 2'b00, 1'b0);   // R8 no gap on new address, R4 empty mask
    @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n} == 4'b1111, "R10 idle release",
        32'({mem_ce_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'hF);
    access(1'b0, 18'h30, 16'h0, 2'b00, 1'b0);
    access(1'b0, 18'h10, 16'h0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", 32'(exp_q.size()), 32'h0);
    chk(model[8'h10] == 16'h12CD, "R4 merged bytes", 32'(model[8'h10]), 32'h12CD);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule